// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals, records which of them are waiting, and decides when to interrupt a processor. Each request line is first brought into the clock domain through a two-flop synchronizer. The request then sets a pending bit, either on a rising edge or for as long as the line is high. A software-written mask can block any level on its own. A pending, unmasked request raises the interrupt output only when it outranks every level that is already being serviced, so that service routines nest strictly by priority.

The processor answers with a one-cycle acknowledge pulse. The controller then returns an 8-bit vector formed from a programmable base and the winning level number, moves that level from pending to in-service, and holds it there until software issues an end-of-interrupt command. Priority is either fixed, with level 0 highest, or rotating, where a level that has just been serviced drops to the bottom of the order. Software can switch between the two at any time. All configuration and status go through a small register port with a three-bit select.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF (all levels blocked), pending and in-service read 0, int_out is low, priority is fixed and triggering is edge mode.
- R2: In edge mode (config bit1 = 0) a pending bit is set by a rising edge of its line. A line that stays high after its acknowledge does not set the bit again.
- R3: In level mode (config bit1 = 1) a pending bit follows the synchronized line. It is set again after an acknowledge while the line stays high, and it clears once the line goes low.
- R4: Select 0 is the mask, and bit i = 1 blocks level i. A masked pending request keeps its pending bit (readable at select 4) but does not raise int_out. The mask reads back as written.
- R5: One cycle after an acknowledge, vec_valid pulses with vec_out = {base[7:3], level}, where the base is written at select 2. In the same cycle the level's in-service bit (select 5) is set and its pending bit is cleared.
- R6: With fixed priority (config bit0 = 0), the lowest-numbered unmasked pending level wins.
- R7: A pending request raises int_out only if it ranks above every in-service level. A request of higher rank raises int_out while a lower one is in service.
- R8: Writing select 3 with bit7 = 0 clears the in-service bit of the level given in bits 2:0.
- R9: Writing select 3 with bit7 = 1 clears the in-service bit of highest current rank.
- R10: With rotating priority (config bit0 = 1), an end-of-interrupt for level L makes L+1 (mod 8) the highest rank and L the lowest.
- R11: An acknowledge while no request is eligible produces no vec_valid and changes no in-service bit.
- R12: Register reads return data on reg_rdata in the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, one per level |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered |
| int_out | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_valid | output | 1 | Vector valid pulse |
| vec_out | output | 8 | Interrupt vector |

## Verification
The assertions assume that irq_ack is a single-cycle pulse and that no end-of-interrupt write lands in the same cycle as an acknowledge for the same level. The assertions also assume that register writes and acknowledges are driven synchronously to clk. The stimulus drives every control input at the falling edge and issues each acknowledge and each register access as a separate one-cycle pulse. After a request line moves, the stimulus waits several cycles so that the synchronizer has settled before any result is compared.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_BASE = 3'd2,
    SEL_EOI  = 3'd3,
    SEL_PEND = 3'd4,
    SEL_SERV = 3'd5
  } pic_sel_e;

  localparam int CFG_ROT_BIT = 0;
  localparam int CFG_LVL_BIT = 1;
  localparam int EOI_ANY_BIT = 7;
endpackage

// File: rtl/pic_req_sync.sv
module pic_req_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] top,
  output logic          found,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[top + LW'(k)]) begin
        found = 1'b1;
        lvl   = top + LW'(k);
        rank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_LVL  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LVL-1:0]  irq_in,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              int_out,
  input  logic              irq_ack,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_out
);
  localparam int LW = $clog2(N_LVL);
  localparam int BW = DATA_W - LW;

  logic [N_LVL-1:0] sync_lvl, sync_rise;
  logic [N_LVL-1:0] pend_q, isr_q, mask_q;
  logic [BW-1:0]    base_q;
  logic             rot_q, trig_lvl_q;
  logic [LW-1:0]    rot_top_q, top;

  logic          w_found, h_found;
  logic [LW-1:0] w_lvl, w_rank, h_lvl, h_rank;
  logic          eligible, take;
  logic          eoi_wr, eoi_do;
  logic [LW-1:0] eoi_lvl;
  logic [N_LVL-1:0] clr_pend, set_isr, clr_isr;

  pic_req_sync #(.N(N_LVL)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .level(sync_lvl), .rise(sync_rise)
  );

  assign top = rot_q ? rot_top_q : '0;

  pic_prio_pick #(.N(N_LVL), .LW(LW)) u_pick_req (
    .req(pend_q & ~mask_q), .top(top), .found(w_found), .lvl(w_lvl), .rank(w_rank)
  );

  pic_prio_pick #(.N(N_LVL), .LW(LW)) u_pick_isr (
    .req(isr_q), .top(top), .found(h_found), .lvl(h_lvl), .rank(h_rank)
  );

  assign eligible = w_found && (!h_found || (w_rank < h_rank));
  assign take     = irq_ack && eligible;

  assign eoi_wr  = reg_wr && (reg_sel == SEL_EOI);
  assign eoi_lvl = reg_wdata[EOI_ANY_BIT] ? h_lvl : reg_wdata[LW-1:0];
  assign eoi_do  = eoi_wr && (!reg_wdata[EOI_ANY_BIT] || h_found);

  always_comb begin
    clr_pend = '0;
    set_isr  = '0;
    clr_isr  = '0;
    if (take) begin
      clr_pend[w_lvl] = 1'b1;
      set_isr[w_lvl]  = 1'b1;
    end
    if (eoi_do) clr_isr[eoi_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      isr_q      <= '0;
      mask_q     <= '1;
      base_q     <= '0;
      rot_q      <= 1'b0;
      trig_lvl_q <= 1'b0;
      rot_top_q  <= '0;
      int_out    <= 1'b0;
      vec_valid  <= 1'b0;
      vec_out    <= '0;
      reg_rdata  <= '0;
    end else begin
      if (trig_lvl_q) pend_q <= sync_lvl & ~clr_pend;
      else            pend_q <= (pend_q | sync_rise) & ~clr_pend;
      isr_q     <= (isr_q | set_isr) & ~clr_isr;
      int_out   <= eligible;
      vec_valid <= take;
      if (take) vec_out <= {base_q, w_lvl};
      if (eoi_do && rot_q) rot_top_q <= eoi_lvl + LW'(1);
      if (reg_wr) begin
        case (reg_sel)
          SEL_MASK: mask_q <= reg_wdata[N_LVL-1:0];
          SEL_CFG: begin
            rot_q      <= reg_wdata[CFG_ROT_BIT];
            trig_lvl_q <= reg_wdata[CFG_LVL_BIT];
          end
          SEL_BASE: base_q <= reg_wdata[DATA_W-1:LW];
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_sel)
          SEL_MASK: reg_rdata <= DATA_W'(mask_q);
          SEL_CFG:  reg_rdata <= DATA_W'({trig_lvl_q, rot_q});
          SEL_BASE: reg_rdata <= {base_q, {LW{1'b0}}};
          SEL_PEND: reg_rdata <= DATA_W'(pend_q);
          SEL_SERV: reg_rdata <= DATA_W'(isr_q);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N_LVL  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_ack,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic              int_out,
  input logic              vec_valid,
  input logic [DATA_W-1:0] vec_out,
  input logic [N_LVL-1:0]  pend,
  input logic [N_LVL-1:0]  isr,
  input logic [N_LVL-1:0]  mask
);
  localparam int LW = $clog2(N_LVL);

  AST_VEC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    !irq_ack |=> !vec_valid); // R11

  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !pend[vec_out[LW-1:0]]); // R5

  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(pend & ~mask))); // R4

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_sel == 3'd0) |=> $stable(mask)); // R4

  AST_SERV_SET_BY_ACK: assert property (@(posedge clk) disable iff (rst)
    !irq_ack |=> ((isr & ~$past(isr)) == '0)); // R5
endmodule

bind prio_irq_ctrl pic_checker #(.N_LVL(N_LVL), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
  .pend(pend_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic [2:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, irq_ack = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, vec_out;
  logic       int_out, vec_valid;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rv;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_out(int_out), .irq_ack(irq_ack), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each vector
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected vector", int'(vec_out), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(vec_out == e, "R5 vector", int'(vec_out), int'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ack(input bit expect_vec, input logic [7:0] v);
    @(negedge clk);
    if (expect_vec) exp_q.push_back(v);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(s, d);
    check(d == e, req, int'(d), int'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    check(int_out == 1'b0, "R1 int_out", int'(int_out), 0);
    rd_chk(3'd0, 8'hFF, "R1 mask reset, R12 read");
    rd_chk(3'd4, 8'h00, "R1 pending reset");
    rd_chk(3'd5, 8'h00, "R1 service reset");
    rd_chk(3'd1, 8'h00, "R1 config reset");

    wr(3'd2, 8'hAB);                 // low three bits dropped -> 0xA8
    wr(3'd0, 8'h00);
    // R6: two at once, lower number wins
    irq_in = 8'h28; idle(6);
    check(int_out, "R6 int raised", int'(int_out), 1);
    ack(1'b1, 8'hAB);
    rd_chk(3'd5, 8'h08, "R5 service set");
    rd_chk(3'd4, 8'h20, "R5 pending cleared");
    idle(3);
    check(!int_out, "R7 lower blocked", int'(int_out), 0);
    irq_in = 8'h2A; idle(6);
    check(int_out, "R7 higher nests", int'(int_out), 1);
    ack(1'b1, 8'hA9);
    rd_chk(3'd5, 8'h0A, "R7 nested service");
    wr(3'd3, 8'h01);
    rd_chk(3'd5, 8'h08, "R8 specific eoi");
    wr(3'd3, 8'h80);
    rd_chk(3'd5, 8'h00, "R9 nonspecific eoi");
    idle(3);
    check(int_out, "R7 unblocked", int'(int_out), 1);
    ack(1'b1, 8'hAD);
    wr(3'd3, 8'h80);
    idle(4);
    rd_chk(3'd4, 8'h00, "R2 held line no re-pend");
    check(!int_out, "R2 no int", int'(int_out), 0);
    irq_in = 8'h00; idle(4);

    // R4 masking, R11 empty ack
    wr(3'd0, 8'h04);
    irq_in = 8'h04; idle(6);
    check(!int_out, "R4 masked no int", int'(int_out), 0);
    rd_chk(3'd4, 8'h04, "R4 masked still pending");
    rd_chk(3'd0, 8'h04, "R4 mask readback");
    ack(1'b0, 8'h00);
    idle(2);
    rd_chk(3'd5, 8'h00, "R11 no service change");
    wr(3'd0, 8'h00); idle(3);
    check(int_out, "R4 unmask raises", int'(int_out), 1);
    ack(1'b1, 8'hAA);
    wr(3'd3, 8'h80);
    irq_in = 8'h00; idle(4);

    // R3 level mode
    wr(3'd1, 8'h02);
    irq_in = 8'h40; idle(6);
    ack(1'b1, 8'hAE);
    idle(4);
    rd_chk(3'd4, 8'h40, "R3 level re-pend");
    irq_in = 8'h00; idle(5);
    rd_chk(3'd4, 8'h00, "R3 level drop clears");
    wr(3'd3, 8'h80);

    // R10 rotating
    wr(3'd1, 8'h01);
    idle(2);
    irq_in = 8'h04; idle(6);
    ack(1'b1, 8'hAA);
    wr(3'd3, 8'h02);                 // level 2 done -> level 3 on top
    irq_in = 8'h00; idle(4);
    irq_in = 8'h14; idle(6);
    ack(1'b1, 8'hAC);                // level 4 outranks level 2 now
    idle(3);
    check(!int_out, "R10 level 2 lowest", int'(int_out), 0);
    wr(3'd3, 8'h80);
    idle(3);
    check(int_out, "R10 after eoi", int'(int_out), 1);
    ack(1'b1, 8'hAA);
    wr(3'd3, 8'h80);
    irq_in = 8'h00;
    idle(4);
    check(exp_q.size() == 0, "R5 all vectors seen", exp_q.size(), 0);
    finish_run();
  end
endmodule